// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block receives write-only configuration traffic for a stereo audio converter over three lines: a serial data line, a serial bit clock and a latch. All three lines are asynchronous to the master clock. They pass through a two-flop synchroniser, and their edges are detected in the master-clock domain. On each rising edge of the serial clock, one data bit is shifted in, most significant bit first. A rising edge on the latch line commits the last 16 bits shifted. The two lowest bits of that frame pick the target register. The upper 14 bits become that register's new contents.

Three registers are held: a left volume word, a right volume word and a control word. The control word is split into fields: rate selection, right-justified word length, soft reset, soft mute, serial format and de-emphasis curve. Several of these fields are merged with external strap pins before they reach the audio path. Every accepted write raises a one-cycle strobe for the register written. A hardware reset restores all defaults. The soft-reset bit holds the audio datapath in reset but leaves the stored registers untouched.

Top module: `serctl_regs`

## Requirements
- R1: While `rst_n` is low at a master-clock edge, and after that edge, both volume registers read 0x3FFF (unity gain), the control word reads 0, and `wr_strobe` is 0.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` in, MSB first. A rising edge of `ser_lat` commits the most recent 16 bits, even when more than 16 were shifted. The register outputs and the strobe change on the third master-clock edge at which `ser_lat` is sampled high.
- R3: Frame bits [1:0] select the register: 00 writes the left volume, 10 writes the right volume, 01 writes the control word. Frame bits [15:2] form the 14-bit value written.
- R4: A frame whose address bits are 11 changes no register and raises no strobe.
- R5: `wr_strobe` is one-hot or zero. Bit 0 marks a left write, bit 1 a right write and bit 2 a control write. Each accepted latch raises exactly one bit, for exactly one master-clock cycle.
- R6: `eff_rate2x` is control bit 11 OR `pin_rate2x`. `eff_rate4x` is control bit 10 OR `pin_rate4x`.
- R7: `eff_mute` is control bit 6 OR `pin_mute`. `eff_fmt` is control bits [5:4] ORed bitwise with `pin_fmt`.
- R8: When `pin_deemph` is high, `eff_deemph` is 01 (the 44.1 kHz curve). Otherwise `eff_deemph` follows control bits [3:2], coded 00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz.
- R9: `eff_wlen` follows control bits [9:8].
- R10: `dp_rst_n` is low while `rst_n` is low or control bit 7 is set. Setting bit 7 leaves both volume registers unchanged.
- R11: A register keeps its value in every cycle in which its strobe bit is not raised. Serial clock activity with no latch edge changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Frame commit, rising-edge active |
| pin_rate2x | input | 1 | Strap forcing double-rate mode |
| pin_rate4x | input | 1 | Strap forcing quad-rate mode |
| pin_mute | input | 1 | Strap forcing mute |
| pin_fmt | input | 2 | Strap serial-format bits |
| pin_deemph | input | 1 | Strap forcing the 44.1 kHz de-emphasis curve |
| vol_left | output | 14 | Left volume register |
| vol_right | output | 14 | Right volume register |
| ctl_word | output | 14 | Raw control register |
| wr_strobe | output | 3 | One-cycle write strobe per register |
| eff_rate2x | output | 1 | Merged double-rate select |
| eff_rate4x | output | 1 | Merged quad-rate select |
| eff_wlen | output | 2 | Right-justified word-length code |
| eff_mute | output | 1 | Merged mute |
| eff_fmt | output | 2 | Merged serial-format code |
| eff_deemph | output | 2 | Resolved de-emphasis curve |
| dp_rst_n | output | 1 | Active-low reset for the audio datapath |

## Verification
The assertions assume that each serial line holds every level for at least three master-clock cycles. This lets the two-flop synchroniser pass every transition. The checks on latch timing and register stability also assume the latch rises only after the final data bit has crossed the synchroniser. The stimulus holds each serial-clock phase and each data bit for three master cycles. It raises the latch three cycles after the last clock edge and keeps it high for at least four cycles. It also keeps the serial clock low across each hardware reset, so that releasing reset cannot look like a clock edge.

// File: rtl/serctl_pkg.sv
// Shared constants and the control-word layout for the serial control port.
package serctl_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_BITS  = 2;
    localparam int WORD_BITS  = FRAME_BITS - ADDR_BITS;
    localparam int NUM_REGS   = 3;

    // Register select codes carried in the low frame bits.
    typedef enum logic [ADDR_BITS-1:0] {
        SEL_LEFT  = 2'b00,
        SEL_CTL   = 2'b01,
        SEL_RIGHT = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;

    // Strobe bit order: 0 = left, 1 = right, 2 = control.
    localparam int IDX_LEFT  = 0;
    localparam int IDX_RIGHT = 1;
    localparam int IDX_CTL   = 2;

    // Control word, MSB first: bits 13:12 spare, 11 double rate, 10 quad rate,
    // 9:8 word length, 7 soft reset, 6 soft mute, 5:4 format, 3:2 de-emphasis,
    // 1:0 spare.
    typedef struct packed {
        logic [1:0] spare_hi;
        logic       rate2x;
        logic       rate4x;
        logic [1:0] wlen;
        logic       soft_rst;
        logic       soft_mute;
        logic [1:0] fmt;
        logic [1:0] deemph;
        logic [1:0] spare_lo;
    } ctl_fields_t;

    localparam logic [1:0] DEEMPH_44K1 = 2'b01;

    // Maps a strobe index to its register select code.
    function automatic logic [ADDR_BITS-1:0] sel_of(input int idx);
        case (idx)
            IDX_LEFT:  return SEL_LEFT;
            IDX_RIGHT: return SEL_RIGHT;
            default:   return SEL_CTL;
        endcase
    endfunction
endpackage

// File: rtl/serctl_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit lines.
// Assumes each line holds a level long enough to be sampled at least twice.
module serctl_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] level
);
    logic [LINES-1:0] stage_q [STAGES];

    // First stage samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign level = stage_q[STAGES-1];
endmodule

// File: rtl/serctl_edge.sv
// Rising-edge detector for synchronised lines; one pulse per low-to-high step.
// Assumes inputs are already in the clk domain.
module serctl_edge #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level,
    output logic [LINES-1:0] rise
);
    logic [LINES-1:0] prev_q;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/serctl_shift.sv
// Serial-to-parallel shifter: MSB-first, keeps the most recent FRAME_W bits.
// Assumes shift_en is a single-cycle pulse per serial clock rising edge.
module serctl_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sr_q;

    // Shift one bit in at the low end on every detected clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], bit_in};
    end

    assign frame = sr_q;
endmodule

// File: rtl/serctl_regfile.sv
// Holds the three addressable registers and issues a registered write strobe.
// Assumes commit is a one-cycle pulse and frame is stable while it is high.
module serctl_regfile
    import serctl_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int ADDR_W  = ADDR_BITS,
    parameter int NREGS   = NUM_REGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [FRAME_W-1:0]         frame,
    output logic [FRAME_W-ADDR_W-1:0]  regs [NREGS],
    output logic [NREGS-1:0]           strobe
);
    localparam int PAY_W = FRAME_W - ADDR_W;

    logic [ADDR_W-1:0] sel;
    logic [PAY_W-1:0]  payload;

    assign sel     = frame[ADDR_W-1:0];
    assign payload = frame[FRAME_W-1:ADDR_W];

    genvar i;
    generate
        for (i = 0; i < NREGS; i++) begin : g_reg
            localparam logic [PAY_W-1:0] RST_VAL = (i == IDX_CTL) ? '0 : '1;
            logic hit;
            assign hit = commit && (sel == sel_of(i));

            // Store the payload when this register is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)   regs[i] <= RST_VAL;
                else if (hit) regs[i] <= payload;
            end

            // Flag the write for exactly one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) strobe[i] <= 1'b0;
                else        strobe[i] <= hit;
            end
        end
    endgenerate
endmodule

// File: rtl/serctl_decode.sv
// Resolves control fields against strap pins into the effective settings.
// Assumes strap pins are quasi-static; the merge is purely combinational.
module serctl_decode
    import serctl_pkg::*;
(
    input  logic       rst_n,
    input  logic       f_rate2x,
    input  logic       f_rate4x,
    input  logic [1:0] f_wlen,
    input  logic       f_soft_rst,
    input  logic       f_soft_mute,
    input  logic [1:0] f_fmt,
    input  logic [1:0] f_deemph,
    input  logic       pin_rate2x,
    input  logic       pin_rate4x,
    input  logic       pin_mute,
    input  logic [1:0] pin_fmt,
    input  logic       pin_deemph,
    output logic       eff_rate2x,
    output logic       eff_rate4x,
    output logic [1:0] eff_wlen,
    output logic       eff_mute,
    output logic [1:0] eff_fmt,
    output logic [1:0] eff_deemph,
    output logic       dp_rst_n
);
    // Merge register fields with straps; the de-emphasis pin overrides.
    always_comb begin
        eff_rate2x = f_rate2x | pin_rate2x;
        eff_rate4x = f_rate4x | pin_rate4x;
        eff_wlen   = f_wlen;
        eff_mute   = f_soft_mute | pin_mute;
        eff_fmt    = f_fmt | pin_fmt;
        eff_deemph = pin_deemph ? DEEMPH_44K1 : f_deemph;
        dp_rst_n   = rst_n & ~f_soft_rst;
    end
endmodule

// File: rtl/serctl_regs.sv
// Top of the three-wire control port: synchronise, detect edges, shift,
// commit to the addressed register, then merge control fields with straps.
// Assumes serial lines change no faster than every SYNC_STAGES+1 master cycles.
module serctl_regs
    import serctl_pkg::*;
#(
    parameter int FRAME_W     = FRAME_BITS,
    parameter int ADDR_W      = ADDR_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_clk,
    input  logic                      ser_dat,
    input  logic                      ser_lat,
    input  logic                      pin_rate2x,
    input  logic                      pin_rate4x,
    input  logic                      pin_mute,
    input  logic [1:0]                pin_fmt,
    input  logic                      pin_deemph,
    output logic [FRAME_W-ADDR_W-1:0] vol_left,
    output logic [FRAME_W-ADDR_W-1:0] vol_right,
    output logic [FRAME_W-ADDR_W-1:0] ctl_word,
    output logic [NUM_REGS-1:0]       wr_strobe,
    output logic                      eff_rate2x,
    output logic                      eff_rate4x,
    output logic [1:0]                eff_wlen,
    output logic                      eff_mute,
    output logic [1:0]                eff_fmt,
    output logic [1:0]                eff_deemph,
    output logic                      dp_rst_n
);
    localparam int PAY_W   = FRAME_W - ADDR_W;
    localparam int L_CLK   = 0;
    localparam int L_DAT   = 1;
    localparam int L_LAT   = 2;
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines, sync_lines;
    logic [1:0]         edges;
    logic [FRAME_W-1:0] frame;
    logic [PAY_W-1:0]   regs [NUM_REGS];
    ctl_fields_t        ctl;

    assign raw_lines = {ser_lat, ser_dat, ser_clk};

    serctl_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw_lines), .level(sync_lines)
    );

    serctl_edge #(.LINES(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .level({sync_lines[L_LAT], sync_lines[L_CLK]}), .rise(edges)
    );

    serctl_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(edges[0]),
        .bit_in(sync_lines[L_DAT]), .frame(frame)
    );

    serctl_regfile #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .NREGS(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .commit(edges[1]), .frame(frame),
        .regs(regs), .strobe(wr_strobe)
    );

    assign vol_left  = regs[IDX_LEFT];
    assign vol_right = regs[IDX_RIGHT];
    assign ctl_word  = regs[IDX_CTL];
    assign ctl       = ctl_fields_t'(regs[IDX_CTL]);

    serctl_decode u_dec (
        .rst_n(rst_n),
        .f_rate2x(ctl.rate2x), .f_rate4x(ctl.rate4x), .f_wlen(ctl.wlen),
        .f_soft_rst(ctl.soft_rst), .f_soft_mute(ctl.soft_mute),
        .f_fmt(ctl.fmt), .f_deemph(ctl.deemph),
        .pin_rate2x(pin_rate2x), .pin_rate4x(pin_rate4x), .pin_mute(pin_mute),
        .pin_fmt(pin_fmt), .pin_deemph(pin_deemph),
        .eff_rate2x(eff_rate2x), .eff_rate4x(eff_rate4x), .eff_wlen(eff_wlen),
        .eff_mute(eff_mute), .eff_fmt(eff_fmt), .eff_deemph(eff_deemph),
        .dp_rst_n(dp_rst_n)
    );
endmodule

// File: rtl/serctl_checks.sv
// Assertion checker for serctl_regs, attached by bind below.
// Assumes the latch is held low for at least four cycles between commits.
module serctl_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_lat,
    input logic        pin_rate2x,
    input logic        pin_deemph,
    input logic        pin_mute,
    input logic [13:0] vol_left,
    input logic [13:0] vol_right,
    input logic [2:0]  wr_strobe,
    input logic        eff_rate2x,
    input logic        eff_mute,
    input logic [1:0]  eff_deemph
);
    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));

    assert_strobe_after_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe != 3'b000) |-> ($past(ser_lat, 3) && !$past(ser_lat, 4)));

    assert_left_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_strobe[0]) |-> $stable(vol_left));

    assert_right_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_strobe[1]) |-> $stable(vol_right));

    assert_pin_rate2x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rate2x |-> eff_rate2x);

    assert_pin_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mute |-> eff_mute);

    assert_pin_deemph_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_deemph |-> (eff_deemph == 2'b01));
endmodule

bind serctl_regs serctl_checks u_checks (
    .clk(clk), .rst_n(rst_n), .ser_lat(ser_lat),
    .pin_rate2x(pin_rate2x), .pin_deemph(pin_deemph), .pin_mute(pin_mute),
    .vol_left(vol_left), .vol_right(vol_right), .wr_strobe(wr_strobe),
    .eff_rate2x(eff_rate2x), .eff_mute(eff_mute), .eff_deemph(eff_deemph)
);

// File: tb/tb_serctl_regs.sv
module tb_serctl_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic pin_rate2x = 1'b0, pin_rate4x = 1'b0, pin_mute = 1'b0, pin_deemph = 1'b0;
    logic [1:0] pin_fmt = 2'b00;
    logic [13:0] vol_left, vol_right, ctl_word;
    logic [2:0]  wr_strobe;
    logic eff_rate2x, eff_rate4x, eff_mute, dp_rst_n;
    logic [1:0] eff_wlen, eff_fmt, eff_deemph;

    int total = 0, bad = 0;
    bit done = 0, cmp_en = 0;

    // Reference state, kept behaviourally.
    logic [13:0] m_left = 14'h3FFF, m_right = 14'h3FFF, m_ctl = 14'h0;
    logic [2:0]  m_stb = 3'b000;
    logic [15:0] m_sr = 16'h0;

    always #4 clk = ~clk;

    serctl_regs dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .pin_rate2x(pin_rate2x), .pin_rate4x(pin_rate4x), .pin_mute(pin_mute),
        .pin_fmt(pin_fmt), .pin_deemph(pin_deemph),
        .vol_left(vol_left), .vol_right(vol_right), .ctl_word(ctl_word),
        .wr_strobe(wr_strobe), .eff_rate2x(eff_rate2x), .eff_rate4x(eff_rate4x),
        .eff_wlen(eff_wlen), .eff_mute(eff_mute), .eff_fmt(eff_fmt),
        .eff_deemph(eff_deemph), .dp_rst_n(dp_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference state.
    always @(posedge clk) begin
        #2;
        if (cmp_en && !done) begin
            chk(vol_left == m_left, "R3 vol_left", vol_left, m_left);
            chk(vol_right == m_right, "R3 vol_right", vol_right, m_right);
            chk(ctl_word == m_ctl, "R3 ctl_word", ctl_word, m_ctl);
            chk(wr_strobe == m_stb, "R5 wr_strobe", wr_strobe, m_stb);
            chk(eff_rate2x == (m_ctl[11] | pin_rate2x), "R6 rate2x", eff_rate2x, m_ctl[11] | pin_rate2x);
            chk(eff_rate4x == (m_ctl[10] | pin_rate4x), "R6 rate4x", eff_rate4x, m_ctl[10] | pin_rate4x);
            chk(eff_wlen == m_ctl[9:8], "R9 wlen", eff_wlen, m_ctl[9:8]);
            chk(eff_mute == (m_ctl[6] | pin_mute), "R7 mute", eff_mute, m_ctl[6] | pin_mute);
            chk(eff_fmt == (m_ctl[5:4] | pin_fmt), "R7 fmt", eff_fmt, m_ctl[5:4] | pin_fmt);
            chk(eff_deemph == (pin_deemph ? 2'b01 : m_ctl[3:2]), "R8 deemph",
                eff_deemph, pin_deemph ? 2'b01 : m_ctl[3:2]);
            chk(dp_rst_n == (rst_n & ~m_ctl[7]), "R10 dp_rst_n", dp_rst_n, rst_n & ~m_ctl[7]);
        end
    end

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ser_clk = 1'b0; ser_lat = 1'b0;
        @(posedge clk);
        m_left = 14'h3FFF; m_right = 14'h3FFF; m_ctl = 14'h0; m_stb = 3'b000; m_sr = 16'h0;
        cmp_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = bits[i];
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            m_sr = {m_sr[14:0], bits[i]};
            repeat (2) @(negedge clk);
        end
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic latch();
        @(negedge clk);
        ser_lat = 1'b1;
        repeat (3) @(posedge clk);
        case (m_sr[1:0])
            2'b00: begin m_left  = m_sr[15:2]; m_stb = 3'b001; end
            2'b10: begin m_right = m_sr[15:2]; m_stb = 3'b010; end
            2'b01: begin m_ctl   = m_sr[15:2]; m_stb = 3'b100; end
            default: m_stb = 3'b000;
        endcase
        @(posedge clk);
        m_stb = 3'b000;
        repeat (2) @(negedge clk);
        ser_lat = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [13:0] val);
        send_bits({16'h0, val, sel}, 16);
        latch();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        hw_reset();
        // R1: defaults after reset
        chk(vol_left == 14'h3FFF, "R1 left default", vol_left, 14'h3FFF);
        chk(vol_right == 14'h3FFF, "R1 right default", vol_right, 14'h3FFF);
        chk(ctl_word == 14'h0, "R1 ctl default", ctl_word, 0);
        chk(wr_strobe == 3'b000, "R1 strobe idle", wr_strobe, 0);

        // R3: address decode for both volumes
        write_reg(2'b00, 14'h1234);
        write_reg(2'b10, 14'h0ABC);
        chk(vol_left == 14'h1234, "R3 left write", vol_left, 14'h1234);
        chk(vol_right == 14'h0ABC, "R3 right write", vol_right, 14'h0ABC);

        // R6 R7 R8 R9: control fields, pins low then high
        write_reg(2'b01, 14'b00_1_0_10_0_1_10_10_00);
        chk(eff_deemph == 2'b10, "R8 deemph 32k", eff_deemph, 2'b10);
        chk(eff_wlen == 2'b10, "R9 wlen", eff_wlen, 2'b10);
        @(negedge clk);
        pin_rate4x = 1'b1; pin_mute = 1'b1; pin_fmt = 2'b01; pin_deemph = 1'b1;
        repeat (3) @(negedge clk);
        chk(eff_deemph == 2'b01, "R8 deemph pin", eff_deemph, 2'b01);
        chk(eff_fmt == 2'b11, "R7 fmt merge", eff_fmt, 2'b11);
        @(negedge clk);
        pin_rate4x = 1'b0; pin_mute = 1'b0; pin_fmt = 2'b00; pin_deemph = 1'b0;
        pin_rate2x = 1'b1;
        write_reg(2'b01, 14'b00_0_1_01_0_0_11_11_00);
        chk(eff_rate2x == 1'b1 && eff_rate4x == 1'b1, "R6 rate merge", {eff_rate2x, eff_rate4x}, 3);
        @(negedge clk);
        pin_rate2x = 1'b0;

        // R4: unused address
        write_reg(2'b11, 14'h0555);
        chk(vol_left == 14'h1234 && vol_right == 14'h0ABC, "R4 vols untouched", vol_left, 14'h1234);
        chk(ctl_word == 14'b00_0_1_01_0_0_11_11_00, "R4 ctl untouched", ctl_word, 14'b00_0_1_01_0_0_11_11_00);

        // R2: 20 bits then latch keeps the last 16
        send_bits({12'h0, 4'hF, 14'h2468, 2'b00}, 20);
        latch();
        chk(vol_left == 14'h2468, "R2 last sixteen", vol_left, 14'h2468);

        // R11: clocking without a latch
        send_bits({16'h0, 14'h3333, 2'b10}, 16);
        repeat (6) @(negedge clk);
        chk(vol_right == 14'h0ABC, "R11 no latch", vol_right, 14'h0ABC);
        latch();
        chk(vol_right == 14'h3333, "R11 later latch", vol_right, 14'h3333);

        // R10: soft reset keeps registers
        write_reg(2'b01, 14'h0080);
        chk(dp_rst_n == 1'b0, "R10 soft reset active", dp_rst_n, 0);
        chk(vol_left == 14'h2468 && vol_right == 14'h3333, "R10 vols kept", vol_left, 14'h2468);
        write_reg(2'b01, 14'h0000);
        chk(dp_rst_n == 1'b1, "R10 soft reset released", dp_rst_n, 1);

        // R1: hardware reset after traffic
        hw_reset();
        chk(vol_left == 14'h3FFF && vol_right == 14'h3FFF, "R1 vols after reset", vol_left, 14'h3FFF);
        chk(ctl_word == 14'h0, "R1 ctl after reset", ctl_word, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule